// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This unit multiplies two WIDTH-bit integers over several clock cycles. It uses one WIDTH-bit adder and a single 2*WIDTH-bit product register. A start pulse captures both operands and a signedness select. The unit then runs WIDTH iterations. In each one it looks at the lowest bit of the product register. When that bit is set, the multiplicand is added into the upper half of the register. After that the whole register, including the adder's carry-out, moves one place to the right. The multiplier is loaded into the lower half of the product register, and these same shifts use it up, so it needs no register of its own.

For a signed operation the unit first converts both operands to their magnitudes and multiplies those as unsigned numbers. If the two operand signs differ, it negates the 2*WIDTH-bit result at the end. The upper half of the final product is written to a high-result register and the lower half to a low-result register, both of which can be read directly. A one-cycle completion pulse marks the write. Both result registers keep their contents until the next operation completes.

Top module: `seq_mult`

## Requirements
- R1: While reset is low, and after its release until the first operation completes, busy, done, hi_q and lo_q are all 0; a reset during an operation abandons it.
- R2: With is_signed = 0, {hi_q, lo_q} equals op_a * op_b as unsigned integers, with hi_q holding bits [2*WIDTH-1:WIDTH] of the product.
- R3: With is_signed = 1, {hi_q, lo_q} equals the 2*WIDTH-bit two's-complement product of op_a and op_b read as two's-complement values.
- R4: Let edge 0 be the clock edge that samples start high while busy is 0. done is high exactly after edge WIDTH+1. busy is high from edge 0 until that edge and is 0 while done is high.
- R5: done stays high for exactly one cycle per accepted operation.
- R6: A start seen while busy is 1 is ignored: the result, the latency and the number of done pulses are those of the operation already in progress.
- R7: hi_q and lo_q change only on the edge that raises done, and keep the previous result while a new operation runs.
- R8: The adder's carry-out is kept, so all-ones unsigned operands give (2^WIDTH-1)^2, with hi_q = all ones except bit 0 cleared.
- R9: In signed mode the most negative operand value (only bit WIDTH-1 set) is handled by its magnitude 2^(WIDTH-1), both alone and when paired with itself.
- R10: op_a, op_b and is_signed are sampled only on the accepting edge; changing them while busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new multiply; accepted only when not busy |
| is_signed | input | 1 | 1 selects two's-complement operands, 0 unsigned |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result registers are written |
| hi_q | output | WIDTH | Upper half of the latest product |
| lo_q | output | WIDTH | Lower half of the latest product |

## Verification
The bench builds the unit with WIDTH = 8. At that width the expected 16-bit products can be computed directly in the bench. The signed extreme of -128 can be paired with itself, with +127 and with +1, and all-ones unsigned operands push the upper half right up to its carry limit. The narrow width also keeps each operation to nine cycles. This leaves room for a table walk, a long pseudo-random run over both modes, and directed tests that disturb the operands and start while the unit is busy.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;

endpackage

// File: rtl/mul_sign_prep.sv
module mul_sign_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             is_signed,
  output logic [WIDTH-1:0] mag_a,
  output logic [WIDTH-1:0] mag_b,
  output logic             neg_res
);

  // Magnitude of a value; in unsigned mode the value passes unchanged.
  // The most negative value maps to 2^(WIDTH-1), which still fits unsigned.
  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v,
                                                 input logic sgn);
    if (sgn && v[WIDTH-1]) return (~v) + 1'b1;
    return v;
  endfunction

  always_comb begin
    mag_a   = magnitude(op_a, is_signed);
    mag_b   = magnitude(op_b, is_signed);
    neg_res = is_signed & (op_a[WIDTH-1] ^ op_b[WIDTH-1]);
  end

endmodule

// File: rtl/mul_step_datapath.sv
module mul_step_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mag_a,
  input  logic [WIDTH-1:0]   mag_b,
  output logic [2*WIDTH-1:0] prod
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH:0]   sum_w;
  logic             add_carry;
  logic             add_en;

  // One iteration of the adder: the multiplicand joins the upper half only
  // when the current multiplier bit is set; the extra bit holds the carry.
  function automatic logic [WIDTH:0] add_step(input logic [WIDTH-1:0] upper,
                                              input logic [WIDTH-1:0] mc,
                                              input logic en);
    if (en) return {1'b0, upper} + {1'b0, mc};
    return {1'b0, upper};
  endfunction

  assign add_en    = prod_q[0];
  assign sum_w     = add_step(prod_q[PW-1:WIDTH], mcand_q, add_en);
  assign add_carry = sum_w[WIDTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mag_a;
      prod_q  <= {{WIDTH{1'b0}}, mag_b};
    end else if (step) begin
      // carry + sum become the new top WIDTH+1 bits; the multiplier half
      // drops its tested bit
      prod_q <= {sum_w, prod_q[WIDTH-1:1]};
    end
  end

  assign prod = prod_q;

  // R8: a carry out of the adder is not lost; it lands in the top bit
  a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step && add_carry) |=> prod_q[PW-1]);

  // R10: the multiplicand stays put between accepting edges
  a_r10_mcand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mcand_q));

endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
  import seqmul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step,
  output logic finish,
  output logic done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy   = (state_q != ST_IDLE);
  assign load   = (state_q == ST_IDLE) && start;
  assign step   = (state_q == ST_RUN);
  assign finish = (state_q == ST_FIN);
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: each running cycle advances the iteration count by one
  a_r4_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

  // R4: the iteration count never runs past the operand width
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q <= LAST_STEP));

  // R5: completion lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a start while running does not restart the iteration count
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start && cnt_q != LAST_STEP) |=> (state_q == ST_RUN && cnt_q != '0));

endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi_q,
  output logic [WIDTH-1:0] lo_q
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mag_a, mag_b;
  logic             neg_res;
  logic             neg_q;
  logic             load, step, finish;
  logic [PW-1:0]    prod;
  logic [PW-1:0]    result_w;

  // Sign fix applied once at the end: negate the full-width magnitude product.
  function automatic logic [PW-1:0] apply_sign(input logic [PW-1:0] p,
                                               input logic neg);
    if (neg) return (~p) + 1'b1;
    return p;
  endfunction

  mul_sign_prep #(.WIDTH(WIDTH)) prep_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .is_signed (is_signed),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_res   (neg_res)
  );

  mul_seq_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .load   (load),
    .step   (step),
    .finish (finish),
    .done   (done)
  );

  mul_step_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .prod  (prod)
  );

  assign result_w = apply_sign(prod, neg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      if (load) neg_q <= neg_res;
      if (finish) begin
        hi_q <= result_w[PW-1:WIDTH];
        lo_q <= result_w[WIDTH-1:0];
      end
    end
  end

  // R7: result registers move only together with the completion pulse
  a_r7_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi_q) && $stable(lo_q)));

  // R4: completion and busy never overlap
  a_r4_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: busy only ends with a completion pulse
  a_r4_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: tb/seq_mult_tb.sv
module seq_mult_tb_top;

  localparam int W          = 8;
  localparam int PW         = 2 * W;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 12;

  // {is_signed, op_a, op_b}
  localparam logic [2*W:0] VEC [NVEC] = '{
    {1'b0, 8'h08, 8'h09},
    {1'b0, 8'hFF, 8'hFF},
    {1'b0, 8'h00, 8'hAB},
    {1'b0, 8'h01, 8'hC3},
    {1'b0, 8'h80, 8'h80},
    {1'b1, 8'hFF, 8'h01},
    {1'b1, 8'h80, 8'h80},
    {1'b1, 8'h80, 8'h7F},
    {1'b1, 8'h80, 8'h01},
    {1'b1, 8'hF9, 8'h06},
    {1'b1, 8'h00, 8'h80},
    {1'b1, 8'h7F, 8'h7F}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy, done;
  logic [W-1:0] hi_q, lo_q;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_mult #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .op_a      (op_a),
    .op_b      (op_b),
    .busy      (busy),
    .done      (done),
    .hi_q      (hi_q),
    .lo_q      (lo_q)
  );

  // Reference product from integer arithmetic on sign-interpreted operands.
  function automatic logic [PW-1:0] ref_prod(input logic sgn,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    longint va, vb;
    va = longint'(a);
    vb = longint'(b);
    if (sgn && a[W-1]) va = va - (longint'(1) << W);
    if (sgn && b[W-1]) vb = vb - (longint'(1) << W);
    return PW'(va * vb);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Launch one operation and wait for done; lat counts edges after edge 0.
  task automatic run_op(input logic sgn, input logic [W-1:0] a,
                        input logic [W-1:0] b, output int lat);
    @(negedge clk);
    start = 1'b1; is_signed = sgn; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 4 * W) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic full_op(input logic sgn, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    int lat;
    logic [PW-1:0] exp;
    exp = ref_prod(sgn, a, b);
    run_op(sgn, a, b, lat);
    check(lat == W + 1, "R4 latency", PW'(lat), PW'(W + 1));
    check(busy == 1'b0, "R4 busy low at done", PW'(busy), '0);
    check({hi_q, lo_q} == exp, sgn ? "R3 signed product" : "R2 unsigned product",
          {hi_q, lo_q}, exp);
    @(negedge clk);
    check(done == 1'b0, "R5 single-cycle done", PW'(done), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] lfsr;
    logic [PW-1:0] exp;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({busy, done} == 2'b00, "R1 control in reset", PW'({busy, done}), '0);
    check({hi_q, lo_q} == '0, "R1 results in reset", {hi_q, lo_q}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done} == 2'b00, "R1 control after reset", PW'({busy, done}), '0);
    check({hi_q, lo_q} == '0, "R1 results after reset", {hi_q, lo_q}, '0);

    // Table walk (R2, R3, R8 via FFxFF, R9 via 0x80 rows)
    for (int i = 0; i < NVEC; i++) begin
      full_op(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);
    end

    // R8: explicit carry corner
    full_op(1'b0, 8'hFF, 8'hFF);
    check({hi_q, lo_q} == 16'hFE01, "R8 all-ones carry", {hi_q, lo_q}, 16'hFE01);
    // R9: most negative squared
    full_op(1'b1, 8'h80, 8'h80);
    check({hi_q, lo_q} == 16'h4000, "R9 min squared", {hi_q, lo_q}, 16'h4000);

    // R6 and R10: restart attempt and operand churn while busy
    exp = ref_prod(1'b0, 8'h13, 8'h0B);
    @(negedge clk);
    start = 1'b1; is_signed = 1'b0; op_a = 8'h13; op_b = 8'h0B;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 4 * W) begin
      op_a = W'(lat * 37 + 5);
      op_b = ~op_a;
      is_signed = lat[0];
      start = (lat == 2);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == W + 1, "R6 latency unchanged", PW'(lat), PW'(W + 1));
    check({hi_q, lo_q} == exp, "R10 operands held", {hi_q, lo_q}, exp);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < W + 4; k++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      check(extra == 0, "R6 no second done", PW'(extra), '0);
    end

    // R7: old result held while the next operation runs
    @(negedge clk);
    start = 1'b1; is_signed = 1'b0; op_a = 8'h02; op_b = 8'h03;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check({hi_q, lo_q} == exp, "R7 hold mid-operation", {hi_q, lo_q}, exp);
    while (!done) @(negedge clk);
    check({hi_q, lo_q} == 16'h0006, "R7 new result", {hi_q, lo_q}, 16'h0006);

    // Pseudo-random run in both modes (R2, R3)
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      full_op(lfsr[0], lfsr[15:8], lfsr[7:0] ^ lfsr[11:4]);
    end

    // R1: reset in the middle of an operation abandons it
    @(negedge clk);
    start = 1'b1; is_signed = 1'b0; op_a = 8'h55; op_b = 8'h66;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({busy, done} == 2'b00, "R1 mid-op reset control", PW'({busy, done}), '0);
    check({hi_q, lo_q} == '0, "R1 mid-op reset results", {hi_q, lo_q}, '0);
    rst_n = 1'b1;
    repeat (W + 3) @(negedge clk);
    check(done == 1'b0, "R1 abandoned op silent", PW'(done), '0);

    summary();
    $finish;
  end

endmodule